// File: doc/BRIEF.md
# Voltage Identification Decoder and Output Window Monitor

This block turns a 5-bit voltage identification code into a set-point in millivolts. It watches digitized samples of the converter output and judges each one against a window and an overvoltage limit, all derived from that same code. The set-point and the disable request follow the code at once. The power-good flag, the overvoltage flag and the low-side crowbar request are registered. They change only on the clock edge that captures a valid sample.

Unconnected code pins are expected to be pulled to logic 1 outside the block. A fully open bus therefore reads as the all-ones code, which is reserved. That code does not select a voltage. It raises a disable request that the power stage treats like holding soft-start at ground.

Top module: `vid_window_monitor`

## Requirements
- R1: For codes 0 to 30 the set-point output equals 1850 − 25 × code millivolts in the same cycle as the code, and the set-point-valid output is 1.
- R2: For code 31 (all ones), the disable request is 1, set-point-valid is 0 and the set-point output is 0. For every other code the disable request is 0.
- R3: On a clock edge with the sample strobe high and a code other than 31, power-good becomes 1 exactly when sp×88/100 ≤ sample ≤ sp×112/100 (truncating division, inclusive edges). Otherwise it becomes 0.
- R4: On a clock edge with the sample strobe high and a code other than 31, the overvoltage flag becomes 1 exactly when sample ≥ sp×117/100 (truncating). Otherwise it becomes 0.
- R5: The crowbar request is 1 in exactly the cycles in which the overvoltage flag is 1. It drops on the first sampled edge whose sample no longer meets the limit.
- R6: On edges without the sample strobe, power-good, overvoltage and crowbar hold their values, even when the code changes.
- R7: Reset (active low, synchronous) clears power-good, overvoltage and crowbar.
- R8: A sample taken while the code is 31 clears power-good and overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid | input | VID_W | Voltage identification code |
| sample_valid | input | 1 | Strobe marking a new output-voltage sample |
| sample_mv | input | SAMPLE_W | Sensed output voltage in millivolts, unsigned |
| setpoint_mv | output | SP_W | Decoded set-point in millivolts |
| setpoint_valid | output | 1 | Set-point is a regulation target |
| disable_req | output | 1 | Reserved code shuts the converter off |
| power_good | output | 1 | Last sample was inside the window |
| overvolt | output | 1 | Last sample reached the overvoltage limit |
| crowbar_req | output | 1 | Request to hold the low-side switch on |

## Verification
The bench builds the block with its default parameters: a 5-bit code, a 25 mV step down from 1850 mV, and 12-bit samples up to 4095 mV. A 12-bit sample spans every threshold of every code, including 117% of 1850 mV (2164 mV). This lets the bench drive each window edge, each edge ± 1 mV and full-scale values for all 32 codes. Stretches without the strobe, some with the code moving, show that the flags hold.

// File: rtl/vid_window_monitor.sv
module vid_window_monitor #(
  parameter int VID_W     = 5,
  parameter int SAMPLE_W  = 12,
  parameter int SP_W      = 12,
  parameter int TOP_MV    = 1850,
  parameter int STEP_MV   = 25,
  parameter int PG_LO_PCT = 88,
  parameter int PG_HI_PCT = 112,
  parameter int OV_PCT    = 117
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VID_W-1:0]    vid,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample_mv,
  output logic [SP_W-1:0]     setpoint_mv,
  output logic                setpoint_valid,
  output logic                disable_req,
  output logic                power_good,
  output logic                overvolt,
  output logic                crowbar_req
);
  localparam logic [VID_W-1:0] OFF_CODE = '1;

  logic        off;
  logic [31:0] sp32, lo_th, hi_th, ov_th, smp;
  logic        pg_q, ov_q;

  assign off            = (vid == OFF_CODE);
  assign sp32           = off ? 32'd0 : 32'(TOP_MV - STEP_MV * int'(vid));
  assign setpoint_mv    = SP_W'(sp32);
  assign setpoint_valid = !off;
  assign disable_req    = off;

  assign lo_th = sp32 * 32'(PG_LO_PCT) / 32'd100;
  assign hi_th = sp32 * 32'(PG_HI_PCT) / 32'd100;
  assign ov_th = sp32 * 32'(OV_PCT)    / 32'd100;
  assign smp   = 32'(sample_mv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      ov_q <= 1'b0;
    end else if (sample_valid) begin
      pg_q <= !off && (smp >= lo_th) && (smp <= hi_th);
      ov_q <= !off && (smp >= ov_th);
    end
  end

  assign power_good  = pg_q;
  assign overvolt    = ov_q;
  assign crowbar_req = ov_q;
endmodule

module vid_window_monitor_chk #(
  parameter int VID_W    = 5,
  parameter int SAMPLE_W = 12,
  parameter int SP_W     = 12,
  parameter int TOP_MV   = 1850,
  parameter int STEP_MV  = 25
) (
  input logic                clk,
  input logic                rst_n,
  input logic [VID_W-1:0]    vid,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] sample_mv,
  input logic [SP_W-1:0]     setpoint_mv,
  input logic                setpoint_valid,
  input logic                disable_req,
  input logic                power_good,
  input logic                overvolt,
  input logic                crowbar_req
);
  localparam int LOW_MV = TOP_MV - STEP_MV * ((1 << VID_W) - 2);

  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    !disable_req |-> setpoint_valid && int'(setpoint_mv) >= LOW_MV && int'(setpoint_mv) <= TOP_MV);
  a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    disable_req |-> !setpoint_valid && setpoint_mv == '0);
  a_r4_ov_not_pg: assert property (@(posedge clk) disable iff (!rst_n)
    overvolt |-> !power_good);
  a_r5_crowbar_follow: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar_req == overvolt);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(power_good) && $stable(overvolt));
  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disable_req && sample_valid |=> !power_good && !overvolt);
endmodule

bind vid_window_monitor vid_window_monitor_chk #(
  .VID_W(VID_W), .SAMPLE_W(SAMPLE_W), .SP_W(SP_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vid(vid), .sample_valid(sample_valid), .sample_mv(sample_mv),
  .setpoint_mv(setpoint_mv), .setpoint_valid(setpoint_valid), .disable_req(disable_req),
  .power_good(power_good), .overvolt(overvolt), .crowbar_req(crowbar_req)
);

// File: tb/vid_window_monitor_bench.sv
module vid_window_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  vid = 5'd31;
  logic        sample_valid = 1'b0;
  logic [11:0] sample_mv = '0;
  logic [11:0] setpoint_mv;
  logic        setpoint_valid, disable_req, power_good, overvolt, crowbar_req;

  int compared = 0;
  int mismatched = 0;
  bit exp_pg = 0, exp_ov = 0;

  always #2.5 clk = ~clk;

  vid_window_monitor u_vid_window_monitor (
    .clk(clk), .rst_n(rst_n), .vid(vid), .sample_valid(sample_valid), .sample_mv(sample_mv),
    .setpoint_mv(setpoint_mv), .setpoint_valid(setpoint_valid), .disable_req(disable_req),
    .power_good(power_good), .overvolt(overvolt), .crowbar_req(crowbar_req)
  );

  function automatic int ref_sp(int code);
    return (code == 31) ? 0 : 1850 - 25 * code;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_pg = 0; exp_ov = 0;
    end else if (sample_valid) begin
      int sp; int s;
      sp = ref_sp(int'(vid));
      s  = int'(sample_mv);
      exp_pg = (vid != 5'd31) && s * 100 >= sp * 88 - (sp * 88) % 100 && s <= (sp * 112) / 100;
      exp_ov = (vid != 5'd31) && s >= (sp * 117) / 100;
    end
  end

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic compare_all(string hold_tag);
    check("R1 setpoint", int'(setpoint_mv), ref_sp(int'(vid)));
    check("R2 disable", int'(disable_req), int'(vid == 5'd31));
    check("R2 valid", int'(setpoint_valid), int'(vid != 5'd31));
    check({"R3 power_good ", hold_tag}, int'(power_good), int'(exp_pg));
    check({"R4 overvolt ", hold_tag}, int'(overvolt), int'(exp_ov));
    check("R5 crowbar", int'(crowbar_req), int'(exp_ov));
  endtask

  task automatic step(int code, bit v, int s, string tag);
    @(negedge clk);
    compare_all(tag);
    vid = 5'(code); sample_valid = v; sample_mv = 12'(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 reset power_good", int'(power_good), 0);
    check("R7 reset overvolt", int'(overvolt), 0);
    check("R7 reset crowbar", int'(crowbar_req), 0);
    for (int c = 0; c < 32; c++) begin
      int sp, lo, hi, ov;
      sp = ref_sp(c);
      lo = sp * 88 / 100; hi = sp * 112 / 100; ov = sp * 117 / 100;
      step(c, 1, lo - 1, "R8");
      step(c, 1, lo, "R8");
      step(c, 1, sp, "R8");
      step(c, 1, hi, "R8");
      step(c, 1, hi + 1, "R8");
      step(c, 1, ov - 1, "R8");
      step(c, 1, ov, "R5");
      step(c, 0, 0, "R6");
      step((c + 7) % 31, 0, sp, "R6");
      step(c, 1, ov - 1, "R5");
      step(c, 1, 4095, "R8");
      step(c, 1, 0, "R8");
      step(c, 1, sp, "R8");
      step(31 - c, 0, 4095, "R6");
    end
    step(3, 1, 1775, "R3");
    step(3, 0, 0, "R6");
    rst_n = 1'b0;
    step(3, 0, 0, "R7");
    @(negedge clk);
    check("R7 reset clears power_good", int'(power_good), 0);
    check("R7 reset clears crowbar", int'(crowbar_req), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule